// File: doc/BRIEF.md
# Addressed Serial Receiver with Station Filter

This block receives asynchronous serial frames from a line that many stations share. Each frame carries a start bit, a data word sent least significant bit first, one extra bit and a stop bit. The line is oversampled from a programmable divider. Once a frame is assembled, a station filter decides whether it reaches the host.

In plain mode the extra bit is a parity bit, and every frame that is good is delivered. In addressed mode the extra bit tells the two frame kinds apart. When it is 1 the frame is an address frame. Its word is compared with the station's own identity, and the result selects or deselects the station. When it is 0 the frame is a data frame, and it reaches the host only while the station is selected. Otherwise it is dropped without a flag.

The host sees a received word, a full flag with a one-cycle receive interrupt pulse, and three sticky error flags with a one-cycle error interrupt pulse. The error flags are framing, parity and overrun.

Top module: `mpuart_rx`

## Requirements
- R1: A frame is one start bit at 0, DATA_W data bits with the least significant bit first, one extra bit, and one stop bit at 1. Each bit lasts OVS oversample ticks, and one tick occurs every div_i+1 clock cycles.
- R2: A low pulse on the line that ends before the middle of the start bit is rejected. It produces no frame, no flag and no interrupt.
- R3: With mode_addr_i=0, a good frame places its word on rx_data_o, sets rx_full_o and pulses rx_irq_o for one cycle.
- R4: With mode_addr_i=0, parity is checked. If parity_odd_i=0, the data bits and the extra bit together must hold an even number of ones; if parity_odd_i=1, an odd number. On a mismatch par_err_o is set, err_irq_o pulses and the word is not delivered.
- R5: With mode_addr_i=1 and the station not selected, which is the state after reset, frames whose extra bit is 0 are ignored. rx_full_o, rx_irq_o and rx_data_o do not change.
- R6: With mode_addr_i=1, a frame whose extra bit is 1 and whose word equals station_id_i sets selected_o. Address frames are never delivered as data. Data frames that follow while the station is selected are delivered as in R3.
- R7: An address frame whose word differs from station_id_i clears selected_o, and later data frames are dropped.
- R8: A stop bit sampled as 0 sets fr_err_o and pulses err_irq_o. This holds for frames that would have been skipped too. Such a frame is otherwise discarded and does not change the selection.
- R9: rd_ack_i clears rx_full_o.
- R10: If a frame that would be delivered completes while rx_full_o is set and rd_ack_i is low, overrun_o is set and err_irq_o pulses. rx_data_o keeps the earlier word.
- R11: err_clr_i clears fr_err_o, par_err_o and overrun_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Oversample divider; one tick per div_i+1 clocks |
| mode_addr_i | input | 1 | 1 = addressed mode, 0 = plain parity mode |
| parity_odd_i | input | 1 | Parity sense in plain mode, 1 = odd |
| station_id_i | input | DATA_W | Identity of this station |
| rxd_i | input | 1 | Serial line, idle high |
| rd_ack_i | input | 1 | Host has read rx_data_o |
| err_clr_i | input | 1 | Clear all error flags |
| rx_data_o | output | DATA_W | Last delivered word |
| rx_full_o | output | 1 | A delivered word is waiting |
| rx_irq_o | output | 1 | One-cycle pulse on delivery |
| fr_err_o | output | 1 | Sticky framing error |
| par_err_o | output | 1 | Sticky parity error |
| overrun_o | output | 1 | Sticky overrun |
| err_irq_o | output | 1 | One-cycle pulse when an error flag is set |
| selected_o | output | 1 | Station selected by the last good address frame |

## Verification
The bench sends data frames before any address frame. A filter that does not start deselected would deliver them and raise the full flag. It sends a matching address frame and then a mismatching one, each followed by a data frame. A design that treats selection as sticky would still deliver after the mismatch. A framing error is injected on a skipped frame, where a filter that checks selection before framing would stay silent. A second word is delivered without an acknowledge, which catches a design that overwrites the held byte instead of flagging overrun. A short start glitch and a run at a slower divider test how the start bit is confirmed and how bit timing follows div_i.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_BITS  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;
endpackage

// File: rtl/mpuart_tick.sv
module mpuart_tick #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] cnt_q;

   assign tick_o = (cnt_q >= div_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/mpuart_frame.sv
module mpuart_frame
   import mpuart_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              rxd_i,
   output logic              frm_valid_o,
   output logic [DATA_W-1:0] frm_data_o,
   output logic              frm_extra_o,
   output logic              frm_stop_ok_o
);
   localparam int CNT_W = $clog2(OVS);
   localparam int IDX_W = $clog2(DATA_W + 1) + 1;
   localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rx_s;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= rxd_i;
         end
      end else begin : g_syncn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_i};
         end
      end
   endgenerate

   assign rx_s = sync_q[SYNC_STAGES-1];

   rx_state_e        st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [IDX_W-1:0] idx_q;
   logic [DATA_W:0]  shf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q          <= RX_IDLE;
         cnt_q         <= '0;
         idx_q         <= '0;
         shf_q         <= '0;
         frm_valid_o   <= 1'b0;
         frm_data_o    <= '0;
         frm_extra_o   <= 1'b0;
         frm_stop_ok_o <= 1'b0;
      end else begin
         frm_valid_o <= 1'b0;
         unique case (st_q)
            RX_IDLE: begin
               cnt_q <= '0;
               if (!rx_s) st_q <= RX_START;
            end
            RX_START: if (tick_i) begin
               if (cnt_q == MID_CNT) begin
                  cnt_q <= '0;
                  idx_q <= '0;
                  st_q  <= rx_s ? RX_IDLE : RX_BITS;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            RX_BITS: if (tick_i) begin
               if (cnt_q == LAST_CNT) begin
                  cnt_q <= '0;
                  shf_q <= {rx_s, shf_q[DATA_W:1]};
                  if (idx_q == LAST_IDX) st_q <= RX_STOP;
                  else                   idx_q <= idx_q + 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            RX_STOP: if (tick_i) begin
               if (cnt_q == LAST_CNT) begin
                  cnt_q         <= '0;
                  st_q          <= RX_IDLE;
                  frm_valid_o   <= 1'b1;
                  frm_data_o    <= shf_q[DATA_W-1:0];
                  frm_extra_o   <= shf_q[DATA_W];
                  frm_stop_ok_o <= rx_s;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: st_q <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mpuart_filter.sv
module mpuart_filter #(
   parameter int DATA_W     = 8,
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_valid_i,
   input  logic [DATA_W-1:0] frm_data_i,
   input  logic              frm_extra_i,
   input  logic              frm_stop_ok_i,
   input  logic              mode_addr_i,
   input  logic              parity_odd_i,
   input  logic [DATA_W-1:0] station_id_i,
   input  logic              rd_ack_i,
   input  logic              err_clr_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_full_o,
   output logic              rx_irq_o,
   output logic              fr_err_o,
   output logic              par_err_o,
   output logic              overrun_o,
   output logic              err_irq_o,
   output logic              selected_o
);
   logic par_bad;
   logic is_addr;
   logic take;

   generate
      if (HAS_PARITY) begin : g_par
         assign par_bad = !mode_addr_i &&
                          ((^frm_data_i ^ frm_extra_i) != parity_odd_i);
      end else begin : g_nopar
         assign par_bad = 1'b0;
      end
   endgenerate

   assign is_addr = mode_addr_i && frm_extra_i;
   assign take    = !is_addr && (!mode_addr_i || selected_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data_o  <= '0;
         rx_full_o  <= 1'b0;
         rx_irq_o   <= 1'b0;
         fr_err_o   <= 1'b0;
         par_err_o  <= 1'b0;
         overrun_o  <= 1'b0;
         err_irq_o  <= 1'b0;
         selected_o <= 1'b0;
      end else begin
         rx_irq_o  <= 1'b0;
         err_irq_o <= 1'b0;
         if (rd_ack_i) rx_full_o <= 1'b0;
         if (err_clr_i) begin
            fr_err_o  <= 1'b0;
            par_err_o <= 1'b0;
            overrun_o <= 1'b0;
         end
         if (frm_valid_i) begin
            if (!frm_stop_ok_i) begin
               fr_err_o  <= 1'b1;
               err_irq_o <= 1'b1;
            end else if (par_bad) begin
               par_err_o <= 1'b1;
               err_irq_o <= 1'b1;
            end else if (is_addr) begin
               selected_o <= (frm_data_i == station_id_i);
            end else if (take) begin
               if (rx_full_o && !rd_ack_i) begin
                  overrun_o <= 1'b1;
                  err_irq_o <= 1'b1;
               end else begin
                  rx_data_o <= frm_data_i;
                  rx_full_o <= 1'b1;
                  rx_irq_o  <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx #(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int DIV_W       = 12,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_PARITY  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  div_i,
   input  logic              mode_addr_i,
   input  logic              parity_odd_i,
   input  logic [DATA_W-1:0] station_id_i,
   input  logic              rxd_i,
   input  logic              rd_ack_i,
   input  logic              err_clr_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_full_o,
   output logic              rx_irq_o,
   output logic              fr_err_o,
   output logic              par_err_o,
   output logic              overrun_o,
   output logic              err_irq_o,
   output logic              selected_o
);
   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_data_w
         $error("mpuart_rx: DATA_W must lie in 5..9");
      end
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("mpuart_rx: OVS must be even and at least 4");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("mpuart_rx: SYNC_STAGES must lie in 1..4");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("mpuart_rx: DIV_W must be positive");
      end
   endgenerate

   logic              tick;
   logic              frm_valid;
   logic [DATA_W-1:0] frm_data;
   logic              frm_extra;
   logic              frm_stop_ok;

   mpuart_tick #(.DIV_W(DIV_W)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .div_i  (div_i),
      .tick_o (tick)
   );

   mpuart_frame #(
      .DATA_W      (DATA_W),
      .OVS         (OVS),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_frame (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick_i        (tick),
      .rxd_i         (rxd_i),
      .frm_valid_o   (frm_valid),
      .frm_data_o    (frm_data),
      .frm_extra_o   (frm_extra),
      .frm_stop_ok_o (frm_stop_ok)
   );

   mpuart_filter #(
      .DATA_W     (DATA_W),
      .HAS_PARITY (HAS_PARITY)
   ) u_filter (
      .clk           (clk),
      .rst_n         (rst_n),
      .frm_valid_i   (frm_valid),
      .frm_data_i    (frm_data),
      .frm_extra_i   (frm_extra),
      .frm_stop_ok_i (frm_stop_ok),
      .mode_addr_i   (mode_addr_i),
      .parity_odd_i  (parity_odd_i),
      .station_id_i  (station_id_i),
      .rd_ack_i      (rd_ack_i),
      .err_clr_i     (err_clr_i),
      .rx_data_o     (rx_data_o),
      .rx_full_o     (rx_full_o),
      .rx_irq_o      (rx_irq_o),
      .fr_err_o      (fr_err_o),
      .par_err_o     (par_err_o),
      .overrun_o     (overrun_o),
      .err_irq_o     (err_irq_o),
      .selected_o    (selected_o)
   );
endmodule

// File: rtl/mpuart_rx_chk.sv
module mpuart_rx_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frm_valid,
   input logic              frm_extra,
   input logic              frm_stop_ok,
   input logic              mode_addr_i,
   input logic              rd_ack_i,
   input logic [DATA_W-1:0] rx_data_o,
   input logic              rx_full_o,
   input logic              rx_irq_o,
   input logic              fr_err_o,
   input logic              par_err_o,
   input logic              overrun_o,
   input logic              err_irq_o,
   input logic              selected_o
);
   assert_irq_with_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq_o |-> rx_full_o);

   assert_skip_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && mode_addr_i && !frm_extra && !selected_o && !rx_full_o)
      |=> (!rx_full_o && !rx_irq_o));

   assert_sel_only_on_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_valid |=> $stable(selected_o));

   assert_framing_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && !frm_stop_ok) |=> (fr_err_o && err_irq_o));

   assert_err_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_irq_o |-> (fr_err_o || par_err_o || overrun_o));

   assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ack_i && !frm_valid) |=> !rx_full_o);

   assert_hold_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full_o && !rd_ack_i) |=> $stable(rx_data_o));

   assert_overrun_needs_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun_o) |-> $past(rx_full_o));
endmodule

bind mpuart_rx mpuart_rx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frm_valid   (frm_valid),
   .frm_extra   (frm_extra),
   .frm_stop_ok (frm_stop_ok),
   .mode_addr_i (mode_addr_i),
   .rd_ack_i    (rd_ack_i),
   .rx_data_o   (rx_data_o),
   .rx_full_o   (rx_full_o),
   .rx_irq_o    (rx_irq_o),
   .fr_err_o    (fr_err_o),
   .par_err_o   (par_err_o),
   .overrun_o   (overrun_o),
   .err_irq_o   (err_irq_o),
   .selected_o  (selected_o)
);

// File: tb/mpuart_rx_test.sv
module mpuart_rx_test;
   localparam int DATA_W = 8;
   localparam int OVS    = 16;
   localparam int DIV_W  = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [DIV_W-1:0]  div_i = '0;
   logic              mode_addr_i = 1'b0;
   logic              parity_odd_i = 1'b0;
   logic [DATA_W-1:0] station_id_i = 8'h42;
   logic              rxd_i = 1'b1;
   logic              rd_ack_i = 1'b0;
   logic              err_clr_i = 1'b0;
   logic [DATA_W-1:0] rx_data_o;
   logic              rx_full_o, rx_irq_o, fr_err_o, par_err_o;
   logic              overrun_o, err_irq_o, selected_o;

   int checks = 0;
   int failures = 0;
   int irq_cnt = 0;
   int eirq_cnt = 0;

   always #5 clk = ~clk;

   mpuart_rx #(.DATA_W(DATA_W), .OVS(OVS), .DIV_W(DIV_W)) uut (
      .clk(clk), .rst_n(rst_n), .div_i(div_i), .mode_addr_i(mode_addr_i),
      .parity_odd_i(parity_odd_i), .station_id_i(station_id_i), .rxd_i(rxd_i),
      .rd_ack_i(rd_ack_i), .err_clr_i(err_clr_i), .rx_data_o(rx_data_o),
      .rx_full_o(rx_full_o), .rx_irq_o(rx_irq_o), .fr_err_o(fr_err_o),
      .par_err_o(par_err_o), .overrun_o(overrun_o), .err_irq_o(err_irq_o),
      .selected_o(selected_o)
   );

   always @(posedge clk) begin
      if (rx_irq_o)  irq_cnt  <= irq_cnt + 1;
      if (err_irq_o) eirq_cnt <= eirq_cnt + 1;
   end

   task automatic check(input string req, input string what,
                        input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, actual, expected);
      end
   endtask

   task automatic hold_bit(input logic v);
      rxd_i = v;
      repeat (OVS * (int'(div_i) + 1)) @(negedge clk);
   endtask

   task automatic send_frame(input logic [DATA_W-1:0] d, input logic extra,
                             input logic stop);
      @(negedge clk);
      hold_bit(1'b0);
      for (int i = 0; i < DATA_W; i++) hold_bit(d[i]);
      hold_bit(extra);
      hold_bit(stop);
      hold_bit(1'b1);
      hold_bit(1'b1);
   endtask

   function automatic logic even_bit(input logic [DATA_W-1:0] d);
      return ^d;
   endfunction

   task automatic pulse_ack();
      @(negedge clk); rd_ack_i = 1'b1;
      @(negedge clk); rd_ack_i = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); err_clr_i = 1'b1;
      @(negedge clk); err_clr_i = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R5", "full after reset", rx_full_o, 0);
      check("R5", "selected after reset", selected_o, 0);
      check("R8", "errors after reset", {fr_err_o, par_err_o, overrun_o}, 0);
      check("R3", "irq after reset", rx_irq_o, 0);
   endtask

   task automatic t_plain();
      int n0;
      mode_addr_i = 1'b0; parity_odd_i = 1'b0;
      n0 = irq_cnt;
      send_frame(8'hA5, even_bit(8'hA5), 1'b1);
      check("R3", "data even", rx_data_o, 8'hA5);
      check("R3", "full even", rx_full_o, 1);
      check("R3", "irq pulses", irq_cnt - n0, 1);
      pulse_ack();
      check("R9", "full after ack", rx_full_o, 0);
      parity_odd_i = 1'b1;
      send_frame(8'h3C, ~even_bit(8'h3C), 1'b1);
      check("R4", "data odd parity", rx_data_o, 8'h3C);
      check("R4", "no parity error", par_err_o, 0);
      pulse_ack();
   endtask

   task automatic t_parity();
      int e0;
      mode_addr_i = 1'b0; parity_odd_i = 1'b0;
      e0 = eirq_cnt;
      send_frame(8'h01, 1'b0, 1'b1);
      check("R4", "par_err set", par_err_o, 1);
      check("R4", "not delivered", rx_full_o, 0);
      check("R4", "err irq pulses", eirq_cnt - e0, 1);
      pulse_clr();
      check("R11", "par_err cleared", par_err_o, 0);
   endtask

   task automatic t_glitch();
      int n0;
      n0 = irq_cnt;
      @(negedge clk); rxd_i = 1'b0;
      repeat (4) @(negedge clk);
      rxd_i = 1'b1;
      repeat (3 * OVS) @(negedge clk);
      check("R2", "glitch no frame", irq_cnt - n0, 0);
      check("R2", "glitch no error", {fr_err_o, par_err_o, overrun_o}, 0);
      send_frame(8'hC3, even_bit(8'hC3), 1'b1);
      check("R2", "frame after glitch", rx_data_o, 8'hC3);
      pulse_ack();
   endtask

   task automatic t_divider();
      div_i = 12'd2;
      send_frame(8'h5A, even_bit(8'h5A), 1'b1);
      check("R1", "data at div 2", rx_data_o, 8'h5A);
      check("R1", "full at div 2", rx_full_o, 1);
      pulse_ack();
      div_i = '0;
   endtask

   task automatic t_addressed();
      int n0;
      mode_addr_i = 1'b1;
      n0 = irq_cnt;
      send_frame(8'h11, 1'b0, 1'b1);
      check("R5", "skipped full", rx_full_o, 0);
      check("R5", "skipped irq", irq_cnt - n0, 0);
      check("R5", "skipped data kept", rx_data_o, 8'h5A);
      send_frame(8'h42, 1'b1, 1'b1);
      check("R6", "selected on match", selected_o, 1);
      check("R6", "address not delivered", rx_full_o, 0);
      send_frame(8'h77, 1'b0, 1'b1);
      check("R6", "data delivered", rx_data_o, 8'h77);
      check("R6", "full after data", rx_full_o, 1);
      pulse_ack();
      send_frame(8'h43, 1'b1, 1'b1);
      check("R7", "deselected on mismatch", selected_o, 0);
      send_frame(8'h99, 1'b0, 1'b1);
      check("R7", "data dropped", rx_full_o, 0);
      check("R7", "word kept", rx_data_o, 8'h77);
   endtask

   task automatic t_framing();
      int e0;
      e0 = eirq_cnt;
      send_frame(8'h42, 1'b1, 1'b0);
      check("R8", "fr_err on address", fr_err_o, 1);
      check("R8", "no selection change", selected_o, 0);
      send_frame(8'h55, 1'b0, 1'b0);
      check("R8", "fr_err skipped", fr_err_o, 1);
      check("R8", "err irq count", eirq_cnt - e0, 2);
      check("R8", "no delivery", rx_full_o, 0);
      pulse_clr();
      check("R11", "fr_err cleared", fr_err_o, 0);
   endtask

   task automatic t_overrun();
      send_frame(8'h42, 1'b1, 1'b1);
      send_frame(8'h10, 1'b0, 1'b1);
      check("R10", "first word", rx_data_o, 8'h10);
      send_frame(8'h20, 1'b0, 1'b1);
      check("R10", "overrun set", overrun_o, 1);
      check("R10", "earlier word kept", rx_data_o, 8'h10);
      check("R10", "still full", rx_full_o, 1);
      pulse_clr();
      check("R11", "all errors cleared", {fr_err_o, par_err_o, overrun_o}, 0);
      pulse_ack();
      check("R9", "full cleared", rx_full_o, 0);
   endtask

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_plain();
      t_parity();
      t_glitch();
      t_divider();
      t_addressed();
      t_framing();
      t_overrun();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule